// File: doc/BRIEF.md
# Fourth-Order Cascaded Integrator-Comb Decimator

This block is the first decimation stage behind an oversampled delta-sigma modulator. On every clock it accepts a narrow two's-complement sample. It runs that sample through four chained accumulators at the full rate. A phase counter then keeps one accumulator value in every sixteen, and four differencing stages process that reduced stream on a clock enable. The result is one 20-bit word per sixteen input samples, marked by a single-cycle valid strobe.

The filter equals four cascaded sixteen-tap boxcar averages, (1 - z^-16)^4 / (1 - z^-1)^4. Its DC gain is 16^4 = 65536. Every internal register is exactly as wide as the output. The accumulators wrap modulo 2^20, and this wrap cancels in the differencing section. Each arithmetic stage has its own register, so no combinational path spans more than one adder. The block has one clock and no clock divider. Equalisation, gain scaling and further half-band stages are left to blocks downstream.

Top module: `cic4_decimator`

## Requirements
- R1: `in_sample` is read as a 4-bit two's-complement value, so codes 8 to 15 stand for -8 to -1. For example, a constant input of code 15 settles to an output of -65536.
- R2: `out_valid` goes high for exactly one cycle in every sixteen. Counting the first rising edge with `rst_n` high as edge 0, it is high after edges 15, 31, 47 and so on.
- R3: The word presented with the strobe that follows edge 16m+15 is the sum over k = 0..60 of h[k]·x[16m-37-k]. Here h is the impulse response of four cascaded sixteen-tap boxcars, x[t] is the input sampled at edge t, and x is 0 before edge 0.
- R4: For each of the 16 constant input values c, the output settles to exactly c·65536.
- R5: `out_word` does not change in any cycle where `out_valid` is low.
- R6: The accumulators wrap without saturation. Arbitrary full-scale input sequences of any length still give the exact result of R3.
- R7: The first three words after reset are zero, whatever the input.
- R8: The reset is synchronous and active-low. While it is low, `out_word` is 0 and `out_valid` is 0 after the next clock edge, and the phase of the strobe restarts from edge 0 once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sample | input | 4 | Two's-complement modulator sample, one per clock |
| out_word | output | 20 | Decimated two's-complement result |
| out_valid | output | 1 | One-cycle strobe marking a new `out_word` |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any checked activity. They also assume that `in_sample` is always driven to a known value. The bench meets both conditions: it starts every segment with a four-cycle reset, and it drives every input on the falling edge from a fully defined integer. The strobe-spacing and hold properties need an uninterrupted stretch of clocks after reset. Mid-run resets therefore always last whole cycles, so that the phase restarts cleanly.

// File: rtl/cic_pkg.sv
// Shared sizing helpers for the integrator-comb decimator.
// Assumes: the decimation rate is a power of two, given as its log2.
package cic_pkg;

    // Width needed so that a full-scale input cannot overflow the final result.
    function automatic int cic_width(input int in_w, input int order, input int rate_log2);
        return in_w + order * rate_log2;
    endfunction

endpackage

// File: rtl/cic_phase_counter.sv
// Decimation phase counter.
// Counts input-rate clocks and raises a one-cycle enable on the last phase of
// every decimation period. Assumes: a synchronous active-low reset that restarts
// the phase at zero.
module cic_phase_counter #(
    parameter int RATE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic dec_en
);
    localparam logic [RATE_LOG2-1:0] LAST_PHASE = '1;

    logic [RATE_LOG2-1:0] phase_q;

    // Advance the phase by one each clock, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // Enable fires in the cycle that precedes the wrap.
    always_comb dec_en = (phase_q == LAST_PHASE);
endmodule

// File: rtl/cic_integrator_chain.sv
// Input-rate accumulator cascade.
// Sign-extends the narrow sample and feeds it through ORDER registered
// accumulators. Each stage adds the previous stage's register, so every stage is
// also a pipeline register. Assumes: modulo-2^W wrap is acceptable, because the
// comb section cancels it.
module cic_integrator_chain #(
    parameter int IN_W  = 4,
    parameter int ORDER = 4,
    parameter int W     = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] in_sample,
    output logic [W-1:0]    acc_out
);
    localparam int EXT_W = W - IN_W;

    logic [W-1:0] stage_in [ORDER];
    logic [W-1:0] acc_q    [ORDER];

    // Widen the input with its sign bit.
    always_comb stage_in[0] = {{EXT_W{in_sample[IN_W-1]}}, in_sample};

    for (genvar k = 1; k < ORDER; k++) begin : g_link
        // Each later stage consumes the registered sum of the one before it.
        always_comb stage_in[k] = acc_q[k-1];
    end

    for (genvar k = 0; k < ORDER; k++) begin : g_acc
        // Accumulate with plain wraparound, no saturation.
        always_ff @(posedge clk) begin
            if (!rst_n) acc_q[k] <= '0;
            else        acc_q[k] <= acc_q[k] + stage_in[k];
        end
    end

    always_comb acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/cic_comb_chain.sv
// Low-rate differencing cascade.
// On each decimation enable, every stage subtracts its previous input from its
// current input and registers the difference, so each stage is also a pipeline
// register. Assumes: dec_en is a one-cycle pulse once per decimation period.
module cic_comb_chain #(
    parameter int ORDER = 4,
    parameter int W     = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_en,
    input  logic [W-1:0] comb_in,
    output logic [W-1:0] comb_out
);
    logic [W-1:0] stage_in [ORDER];
    logic [W-1:0] prev_q   [ORDER];
    logic [W-1:0] diff_q   [ORDER];

    // The first stage takes the decimated accumulator value.
    always_comb stage_in[0] = comb_in;

    for (genvar k = 1; k < ORDER; k++) begin : g_link
        // Later stages take the registered difference of the stage before.
        always_comb stage_in[k] = diff_q[k-1];
    end

    for (genvar k = 0; k < ORDER; k++) begin : g_comb
        // Keep one low-rate delay and register the first difference.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[k] <= '0;
                diff_q[k] <= '0;
            end else if (dec_en) begin
                prev_q[k] <= stage_in[k];
                diff_q[k] <= stage_in[k] - prev_q[k];
            end
        end
    end

    always_comb comb_out = diff_q[ORDER-1];
endmodule

// File: rtl/cic4_decimator.sv
// Fourth-order, rate-16 integrator-comb decimator (top level).
// Ties the accumulator cascade, the phase counter and the comb cascade
// together, and produces a one-cycle strobe with each new output word.
// Assumes: one sample per clock and a synchronous active-low reset.
module cic4_decimator
    import cic_pkg::*;
#(
    parameter  int IN_W      = 4,
    parameter  int ORDER     = 4,
    parameter  int RATE_LOG2 = 4,
    localparam int OUT_W     = cic_width(IN_W, ORDER, RATE_LOG2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_sample,
    output logic [OUT_W-1:0] out_word,
    output logic             out_valid
);
    logic [OUT_W-1:0] integ_out;
    logic             dec_en;
    logic             valid_q;

    cic_integrator_chain #(
        .IN_W  (IN_W),
        .ORDER (ORDER),
        .W     (OUT_W)
    ) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sample (in_sample),
        .acc_out   (integ_out)
    );

    cic_phase_counter #(
        .RATE_LOG2 (RATE_LOG2)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (dec_en)
    );

    cic_comb_chain #(
        .ORDER (ORDER),
        .W     (OUT_W)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_en   (dec_en),
        .comb_in  (integ_out),
        .comb_out (out_word)
    );

    // Strobe in the same cycle the last comb register takes its new value.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= dec_en;
    end

    always_comb out_valid = valid_q;
endmodule

// File: rtl/cic4_decimator_checker.sv
// Port-level property checker for the decimator, bound to every instance.
// Assumes: reset is asserted at start-up before any checked activity.
module cic4_decimator_checker #(
    parameter int OUT_W     = 20,
    parameter int RATE_LOG2 = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    logic [RATE_LOG2-1:0] since_rst_q;
    logic                 started_q;

    // Independent count of clocks since reset, used to judge strobe spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            started_q   <= 1'b0;
        end else begin
            since_rst_q <= since_rst_q + 1'b1;
            started_q   <= 1'b1;
        end
    end

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_strobe_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst_q == '0 && started_q));

    assert_strobe_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == '0 && started_q) |-> out_valid);

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (out_word == '0 && !out_valid));
endmodule

bind cic4_decimator cic4_decimator_checker #(
    .OUT_W     (OUT_W),
    .RATE_LOG2 (RATE_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/cic4_decimator_bench.sv
module cic4_decimator_bench;
    localparam int HLEN = 61;
    localparam int XMAX = 4096;
    localparam int DC_GAIN = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_sample = '0;
    logic [19:0] out_word;
    logic        out_valid;

    int vecs = 0;
    int errs = 0;
    int h [HLEN];
    int x_hist [XMAX];
    int t_now = 0;
    logic [19:0] last_out = '0;
    bit done = 1'b0;

    cic4_decimator u_cic4_decimator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sample (in_sample),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t_now);
        end
    endtask

    function automatic int xat(input int idx);
        return (idx < 0) ? 0 : x_hist[idx];
    endfunction

    // Build the impulse response of four chained 16-tap boxcars.
    task automatic build_h();
        int tmp [HLEN];
        foreach (h[i]) h[i] = (i < 16) ? 1 : 0;
        for (int s = 1; s < 4; s++) begin
            foreach (tmp[i]) begin
                tmp[i] = 0;
                for (int j = 0; j < 16; j++)
                    if (i - j >= 0) tmp[i] += h[i-j];
            end
            foreach (h[i]) h[i] = tmp[i];
        end
    endtask

    // Enter reset for four cycles, check cleared outputs (R8), then release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_sample = 4'($urandom);
            @(negedge clk);
            chk("R8 valid low in reset", longint'(out_valid), 0);
            chk("R8 word zero in reset", longint'(out_word), 0);
        end
        rst_n = 1'b1;
        t_now = 0;
        last_out = '0;
    endtask

    // Apply one sample at a falling edge and check outputs after the next rising edge.
    task automatic step(input int xv);
        int m;
        longint exp;
        in_sample = xv[3:0];
        x_hist[t_now] = xv;
        @(posedge clk);
        @(negedge clk);
        chk("R2 strobe timing", longint'(out_valid), longint'((t_now % 16) == 15));
        if (out_valid) begin
            m = t_now / 16;
            exp = 0;
            for (int k = 0; k < HLEN; k++) exp += longint'(h[k]) * xat(16*m - 37 - k);
            if (m < 3) chk("R7 early word zero", longint'($signed(out_word)), 0);
            else       chk("R3 R6 filtered word", longint'($signed(out_word)), exp);
            last_out = out_word;
        end else begin
            chk("R5 word held", longint'(out_word), longint'(last_out));
        end
        t_now++;
    endtask

    function automatic int rnd_s4();
        int v;
        v = int'($urandom % 16);
        return (v > 7) ? v - 16 : v;
    endfunction

    initial begin
        build_h();

        // Reset state and silent input.
        do_reset();
        for (int i = 0; i < 64; i++) step(0);

        // Every constant input value (R4, R1 for negatives).
        for (int c = -8; c <= 7; c++) begin
            do_reset();
            for (int i = 0; i < 160; i++) step(c);
            if (c < 0) chk("R1 R4 negative constant", longint'($signed(last_out)), longint'(c) * DC_GAIN);
            else       chk("R4 constant", longint'($signed(last_out)), longint'(c) * DC_GAIN);
        end

        // Single impulse (R3).
        do_reset();
        step(7);
        for (int i = 0; i < 127; i++) step(0);

        // Long full-scale random run forcing accumulator wrap (R6).
        do_reset();
        for (int i = 0; i < 3000; i++) step(rnd_s4());

        // Alternating extremes (R6).
        do_reset();
        for (int i = 0; i < 400; i++) step((i % 2 == 0) ? 7 : -8);

        // Mid-run reset, then early words under random input (R8, R7).
        do_reset();
        for (int i = 0; i < 50; i++) step(rnd_s4());
        do_reset();
        for (int i = 0; i < 160; i++) step(rnd_s4());

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100000 * 4);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule